// File: doc/BRIEF.md
# One-Time-Programmable ROM Burn and Verify Sequencer

This block sits between a command source and the programming pins of a target device whose code ROM can be written only once. Each command carries a 14-bit address, a data byte and a mode: burn, check or signature read. For a burn it drives address and data, sets the target's five mode strap lines, raises the high-voltage enable after a setup window and fires a fixed burst of five long active-low program pulses. It then drops the high-voltage enable after a guard window and holds the buses before going idle.

For check and signature reads the data bus is released. The byte returned by the target is captured at the end of the setup window and compared with the byte carried by the command. A mismatch sets a sticky error. The sequencer then stops accepting work until it is reset. All timing is counted in clock cycles derived from a clock-frequency parameter, with a default of 5 MHz. The target's reset line is driven high for as long as a job runs. The target's gate line and the high-voltage supply itself are handled by the board.

Top module: `otp_prog_seq`

## Requirements
- R1: `cmd_ready` is high only while the sequencer is idle and no error is latched. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` and `tgt_rst` are high from the next cycle until the job ends.
- R2: From the first busy cycle, `tgt_addr` and `tgt_data_o` show the command's address and data. They stay unchanged through the job and remain at those values while idle.
- R3: Mode code 0 is burn, code 1 is check, and codes 2 and 3 are signature read. `tgt_strap` bits 4..0 are 5'b11110 for burn, 5'b11000 for check and 5'b00000 for signature. They read 5'b00000 while idle.
- R4: In a burn, `vpp_en` rises after exactly 48 setup cycles and stays high for 60 cycles (12 µs at 5 MHz) before the first program pulse. `prog_n` is never low while `vpp_en` is low.
- R5: A burn fires exactly five `prog_n` low pulses of 500 cycles each (100 µs). The pulses are separated by 60 high cycles (12 µs).
- R6: After the last pulse, `vpp_en` stays high for 60 more cycles, then falls. The buses are then held for 48 further cycles. `tgt_data_oe` is high only during a burn job.
- R7: In check and signature jobs, `tgt_data_oe` stays low for the 48 busy cycles. `tgt_data_i` is sampled in the last of those cycles and appears on `rd_byte` in the first idle cycle.
- R8: In a check or signature job, a sampled byte that differs from `cmd_data` sets `err` from the first idle cycle. `err` stays set until reset. While it is set, `cmd_ready` is low and commands are ignored.
- R9: `done` pulses high for exactly one cycle, the first idle cycle after each job.
- R10: Commands offered while a job is running have no effect on any output.
- R11: After reset, `busy`, `vpp_en`, `err`, `done`, `tgt_rst` and `tgt_data_oe` are low. `prog_n` and `cmd_ready` are high, and `tgt_addr`, `tgt_data_o` and `rd_byte` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (4 to 6 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_mode | input | 2 | 0 burn, 1 check, 2/3 signature |
| cmd_addr | input | 14 | Target ROM address |
| cmd_data | input | 8 | Byte to burn, or byte expected on readback |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job-complete pulse |
| err | output | 1 | Sticky readback mismatch |
| rd_byte | output | 8 | Last byte read back from the target |
| tgt_addr | output | 14 | Target address lines |
| tgt_data_o | output | 8 | Target data lines, driven value |
| tgt_data_oe | output | 1 | Drive enable for the target data lines |
| tgt_data_i | input | 8 | Target data lines, returned value |
| tgt_rst | output | 1 | Target reset line, high during a job |
| tgt_strap | output | 5 | Mode straps; bits 0..4 go to target port lines 2.6, 2.7, 3.2, 3.6, 3.7 |
| vpp_en | output | 1 | Enables the external programming supply |
| prog_n | output | 1 | Active-low program pulse |

## Verification
The bench predicts every output for every cycle of a job and goes after the pulse-count and window edges. An off-by-one in any phase counter would stretch or shorten a 500-cycle pulse or a 60-cycle guard. Dropping `vpp_en` one phase early would expose the last pulse's trailing edge without high voltage. It keeps `cmd_valid` high with changed fields through the first 100 cycles of a burn, so a design that re-latched commands mid-job would show a new address. It reads back a wrong byte, then offers another command. A design whose error was not sticky, or that still accepted work after the error, would start a new job. It uses mode code 3 to confirm the signature alias.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_VPP_UP,
        S_PULSE,
        S_GAP,
        S_VPP_DN,
        S_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_BURN,
        OP_CHECK,
        OP_SIGN
    } op_e;

    // strap vector bits 4..0 = target lines 3.7, 3.6, 3.2, 2.7, 2.6
    localparam logic [4:0] STRAP_BURN  = 5'b11110;
    localparam logic [4:0] STRAP_CHECK = 5'b11000;
    localparam logic [4:0] STRAP_SIGN  = 5'b00000;

    function automatic op_e decode_op(input logic [1:0] code);
        if (code[1])      return OP_SIGN;
        else if (code[0]) return OP_CHECK;
        else              return OP_BURN;
    endfunction

endpackage

// File: rtl/otp_phase_timer.sv
`timescale 1ns/1ps
module otp_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_strap_map.sv
`timescale 1ns/1ps
module otp_strap_map
    import otp_seq_pkg::*;
(
    input  op_e        op,
    input  logic       active,
    output logic [4:0] strap,
    output logic       tgt_rst,
    output logic       data_oe
);
    always_comb begin
        strap = '0;
        if (active) begin
            unique case (op)
                OP_BURN:  strap = STRAP_BURN;
                OP_CHECK: strap = STRAP_CHECK;
                default:  strap = STRAP_SIGN;
            endcase
        end
    end

    assign tgt_rst = active;
    assign data_oe = active && (op == OP_BURN);
endmodule

// File: rtl/otp_readback.sv
`timescale 1ns/1ps
module otp_readback #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] expected,
    output logic [DATA_W-1:0] rd_byte,
    output logic              err
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic              err;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (sample) begin
            rb_d.rd = din;
            if (din != expected)
                rb_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rd_byte = rb_q.rd;
    assign err     = rb_q.err;
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int CLK_KHZ    = 5000,
    parameter int PULSE_US   = 100,
    parameter int GAP_US     = 12,
    parameter int GUARD_US   = 12,
    parameter int SETUP_CYC  = 48,
    parameter int HOLD_CYC   = 48,
    parameter int NUM_PULSES = 5,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data_o,
    output logic              tgt_data_oe,
    input  logic [DATA_W-1:0] tgt_data_i,
    output logic              tgt_rst,
    output logic [4:0]        tgt_strap,
    output logic              vpp_en,
    output logic              prog_n
);
    localparam int PULSE_CYC = CLK_KHZ * PULSE_US / 1000;
    localparam int GAP_CYC   = CLK_KHZ * GAP_US / 1000;
    localparam int GUARD_CYC = CLK_KHZ * GUARD_US / 1000;
    localparam int MAX_A     = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int MAX_B     = (GUARD_CYC > SETUP_CYC) ? GUARD_CYC : SETUP_CYC;
    localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC   = (MAX_C > HOLD_CYC) ? MAX_C : HOLD_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int PIDX_W    = $clog2(NUM_PULSES + 1);

    typedef struct packed {
        seq_state_e        state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [PIDX_W-1:0] pidx;
        logic              done;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rb_sample;
    logic             rb_err;
    logic             active;

    otp_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    otp_readback #(.DATA_W(DATA_W)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rb_sample),
        .din      (tgt_data_i),
        .expected (seq_q.data),
        .rd_byte  (rd_byte),
        .err      (rb_err)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rb_sample  = 1'b0;
        unique case (seq_q.state)
            S_IDLE: begin
                if (cmd_valid && !rb_err) begin
                    seq_d.state = S_SETUP;
                    seq_d.op    = decode_op(cmd_mode);
                    seq_d.addr  = cmd_addr;
                    seq_d.data  = cmd_data;
                    seq_d.pidx  = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(SETUP_CYC - 1);
                end
            end
            S_SETUP: begin
                if (tmr_expired) begin
                    if (seq_q.op == OP_BURN) begin
                        seq_d.state = S_VPP_UP;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(GUARD_CYC - 1);
                    end else begin
                        rb_sample   = 1'b1;
                        seq_d.state = S_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end
            end
            S_VPP_UP: begin
                if (tmr_expired) begin
                    seq_d.state = S_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (seq_q.pidx == PIDX_W'(NUM_PULSES - 1)) begin
                        seq_d.state = S_VPP_DN;
                        tmr_val     = CNT_W'(GUARD_CYC - 1);
                    end else begin
                        seq_d.state = S_GAP;
                        seq_d.pidx  = seq_q.pidx + 1'b1;
                        tmr_val     = CNT_W'(GAP_CYC - 1);
                    end
                end
            end
            S_GAP: begin
                if (tmr_expired) begin
                    seq_d.state = S_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(PULSE_CYC - 1);
                end
            end
            S_VPP_DN: begin
                if (tmr_expired) begin
                    seq_d.state = S_HOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(HOLD_CYC - 1);
                end
            end
            S_HOLD: begin
                if (tmr_expired) begin
                    seq_d.state = S_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
            seq_q.op    <= OP_BURN;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active = (seq_q.state != S_IDLE);

    otp_strap_map u_strap (
        .op      (seq_q.op),
        .active  (active),
        .strap   (tgt_strap),
        .tgt_rst (tgt_rst),
        .data_oe (tgt_data_oe)
    );

    assign busy       = active;
    assign done       = seq_q.done;
    assign err        = rb_err;
    assign cmd_ready  = !active && !rb_err;
    assign tgt_addr   = seq_q.addr;
    assign tgt_data_o = seq_q.data;
    assign vpp_en     = (seq_q.state == S_VPP_UP) || (seq_q.state == S_PULSE) ||
                        (seq_q.state == S_GAP)    || (seq_q.state == S_VPP_DN);
    assign prog_n     = (seq_q.state != S_PULSE);
endmodule

// File: rtl/otp_prog_seq_chk.sv
`timescale 1ns/1ps
module otp_prog_seq_chk #(
    parameter int PULSE_CYC = 500,
    parameter int GUARD_CYC = 60,
    parameter int ADDR_W    = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              vpp_en,
    input logic              prog_n,
    input logic              tgt_data_oe,
    input logic [4:0]        tgt_strap,
    input logic [ADDR_W-1:0] tgt_addr
);
    int lo_cnt;
    int vpp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt  <= 0;
            vpp_cnt <= 0;
        end else begin
            lo_cnt  <= prog_n ? 0 : lo_cnt + 1;
            vpp_cnt <= vpp_en ? vpp_cnt + 1 : 0;
        end
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy);
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(tgt_addr));
    p_pulse_under_vpp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> vpp_en);
    p_guard_before_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> vpp_cnt >= GUARD_CYC);
    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n) |-> lo_cnt == PULSE_CYC);
    p_oe_burn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_data_oe |-> busy && tgt_strap == 5'b11110);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_ready);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .PULSE_CYC (PULSE_CYC),
    .GUARD_CYC (GUARD_CYC),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .vpp_en      (vpp_en),
    .prog_n      (prog_n),
    .tgt_data_oe (tgt_data_oe),
    .tgt_strap   (tgt_strap),
    .tgt_addr    (tgt_addr)
);

// File: tb/otp_prog_seq_test.sv
`timescale 1ns/1ps
module otp_prog_seq_test;
    localparam int SETUP = 48;
    localparam int GUARD = 60;
    localparam int PULSE = 500;
    localparam int GAP   = 60;
    localparam int NP    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_mode = '0;
    logic [13:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        busy, done, err;
    logic [7:0]  rd_byte;
    logic [13:0] tgt_addr;
    logic [7:0]  tgt_data_o;
    logic        tgt_data_oe;
    logic [7:0]  tgt_data_i = '0;
    logic        tgt_rst;
    logic [4:0]  tgt_strap;
    logic        vpp_en, prog_n;

    always #4 clk = ~clk;

    otp_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .done(done), .err(err), .rd_byte(rd_byte),
        .tgt_addr(tgt_addr), .tgt_data_o(tgt_data_o), .tgt_data_oe(tgt_data_oe),
        .tgt_data_i(tgt_data_i), .tgt_rst(tgt_rst), .tgt_strap(tgt_strap),
        .vpp_en(vpp_en), .prog_n(prog_n)
    );

    typedef struct packed {
        logic        busy;
        logic        ready;
        logic        vpp;
        logic        prog_n;
        logic        trst;
        logic        oe;
        logic        done;
        logic        err;
        logic [4:0]  strap;
        logic [13:0] addr;
        logic [7:0]  data;
        logic [7:0]  rd;
    } exp_t;

    exp_t q[$];
    exp_t idle_e;
    int   checks = 0;
    int   fails  = 0;
    bit   run_cmp = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic exp_t reset_idle();
        exp_t e = '0;
        e.ready  = 1'b1;
        e.prog_n = 1'b1;
        return e;
    endfunction

    function automatic logic [4:0] strap_for(input logic [1:0] m);
        if (m[1])      return 5'b00000;
        else if (m[0]) return 5'b11000;
        else           return 5'b11110;
    endfunction

    task automatic push_n(input exp_t e, input int n);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        exp_t e;
        if (run_cmp) begin
            if (q.size() > 0) e = q.pop_front();
            else              e = idle_e;
            chk("R1", "busy", int'(busy), int'(e.busy));
            chk("R1", "cmd_ready", int'(cmd_ready), int'(e.ready));
            chk("R4", "vpp_en", int'(vpp_en), int'(e.vpp));
            chk("R5", "prog_n", int'(prog_n), int'(e.prog_n));
            chk("R3", "tgt_rst", int'(tgt_rst), int'(e.trst));
            chk("R3", "tgt_strap", int'(tgt_strap), int'(e.strap));
            chk("R6", "tgt_data_oe", int'(tgt_data_oe), int'(e.oe));
            chk("R2", "tgt_addr", int'(tgt_addr), int'(e.addr));
            chk("R2", "tgt_data_o", int'(tgt_data_o), int'(e.data));
            chk("R9", "done", int'(done), int'(e.done));
            chk("R8", "err", int'(err), int'(e.err));
            chk("R7", "rd_byte", int'(rd_byte), int'(e.rd));
        end
    end

    task automatic run_job(input logic [1:0] mode, input logic [13:0] a, input logic [7:0] d,
                           input logic [7:0] din, input bit accept, input int garbage);
        exp_t b;
        exp_t fin;
        @(negedge clk); #1;
        tgt_data_i = din;
        cmd_mode   = mode;
        cmd_addr   = a;
        cmd_data   = d;
        cmd_valid  = 1'b1;
        if (accept) begin
            b        = idle_e;
            b.busy   = 1'b1;
            b.ready  = 1'b0;
            b.trst   = 1'b1;
            b.prog_n = 1'b1;
            b.vpp    = 1'b0;
            b.done   = 1'b0;
            b.strap  = strap_for(mode);
            b.addr   = a;
            b.data   = d;
            if (mode == 2'd0) begin
                b.oe = 1'b1;
                push_n(b, SETUP);
                b.vpp = 1'b1;
                push_n(b, GUARD);
                for (int p = 0; p < NP; p++) begin
                    b.prog_n = 1'b0;
                    push_n(b, PULSE);
                    b.prog_n = 1'b1;
                    if (p < NP - 1) push_n(b, GAP);
                end
                push_n(b, GUARD);
                b.vpp = 1'b0;
                push_n(b, SETUP);
            end else begin
                b.oe = 1'b0;
                push_n(b, SETUP);
                idle_e.rd = din;
                if (din != d) begin
                    idle_e.err   = 1'b1;
                    idle_e.ready = 1'b0;
                end
            end
            idle_e.addr = a;
            idle_e.data = d;
            fin = idle_e;
            fin.done = 1'b1;
            q.push_back(fin);
        end
        @(posedge clk);
        @(negedge clk); #1;
        if (garbage > 0) begin
            cmd_addr = ~a;
            cmd_data = ~d;
            cmd_mode = mode ^ 2'd1;
            repeat (garbage) @(negedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        run_cmp = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        q.delete();
        idle_e = reset_idle();
        @(negedge clk);
        // R11: reset state at the ports
        chk("R11", "busy", int'(busy), 0);
        chk("R11", "vpp_en", int'(vpp_en), 0);
        chk("R11", "prog_n", int'(prog_n), 1);
        chk("R11", "err", int'(err), 0);
        chk("R11", "done", int'(done), 0);
        chk("R11", "cmd_ready", int'(cmd_ready), 1);
        chk("R11", "tgt_data_oe", int'(tgt_data_oe), 0);
        chk("R11", "tgt_rst", int'(tgt_rst), 0);
        chk("R11", "tgt_addr", int'(tgt_addr), 0);
        chk("R11", "rd_byte", int'(rd_byte), 0);
        run_cmp = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_e = reset_idle();
        do_reset();
        // R4 R5 R6: full burn burst
        run_job(2'd0, 14'h0123, 8'hA5, 8'h00, 1'b1, 0);
        // R10: top address, commands held during the burn are ignored
        run_job(2'd0, 14'h3FFF, 8'h00, 8'h00, 1'b1, 100);
        chk("R10", "tgt_addr after ignored cmds", int'(tgt_addr), 14'h3FFF);
        // R7: check read that matches
        run_job(2'd1, 14'h0123, 8'hA5, 8'hA5, 1'b1, 0);
        chk("R7", "rd_byte after check", int'(rd_byte), 8'hA5);
        // R3: signature reads, code 2 and alias code 3
        run_job(2'd2, 14'h0030, 8'h89, 8'h89, 1'b1, 0);
        run_job(2'd3, 14'h0031, 8'h58, 8'h58, 1'b1, 0);
        chk("R7", "signature byte", int'(rd_byte), 8'h58);
        // R8: mismatch latches error
        run_job(2'd1, 14'h3FFF, 8'h00, 8'h01, 1'b1, 0);
        chk("R8", "err after mismatch", int'(err), 1);
        // R8: halted, a new burn is not taken
        run_job(2'd0, 14'h0200, 8'h77, 8'h00, 1'b0, 0);
        chk("R8", "busy while halted", int'(busy), 0);
        chk("R8", "vpp_en while halted", int'(vpp_en), 0);
        // R11: reset clears the halt
        do_reset();
        run_job(2'd1, 14'h0055, 8'h3C, 8'h3C, 1'b1, 0);
        chk("R1", "ready after clean check", int'(cmd_ready), 1);
        run_cmp = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule